// File: doc/BRIEF.md
# Two-Channel Bus-Master DMA Control Registers

This block holds the control registers that software programs for a two-channel bus-master disk DMA engine. The registers sit in a 16-byte I/O window. Address bit 3 selects the channel, so each channel has 8 bytes. In the lower half of a channel's 8 bytes are a command byte and a status byte. In the upper half is a 32-bit descriptor-table pointer. Software reaches them over a simple strobed I/O bus. Each access carries an address, a size code, write data, a read strobe and a write strobe. Read data returns one clock after the read strobe.

The DMA engine reports three things per channel: whether a transfer is in progress, an error pulse and an interrupt pulse. The block records these in the status byte. It drives the start, direction and table pointer of each channel back to the engine from registers.

The status byte has several kinds of bit. The activity bit is read-only. The error and interrupt flags are cleared by writing a 1 to them. Two capability bits can be read and written freely. The command and status half of each channel responds only to single-byte accesses.

Top module: `bmd_regfile`

## Requirements
- R1: After a synchronous reset, every command, status and table-pointer register is zero. Read data is zero, and the start, direction and table outputs are zero.
- R2: Address bit 3 selects channel 0 (value 0) or channel 1 (value 1). An access to one channel never changes the other channel.
- R3: Size code 0 is a byte access. A byte read at channel offset 0 returns the command byte and a byte read at offset 2 returns the status byte. A byte read at offset 1 or 3 returns 0xFF. Read data appears on the clock after the read strobe and holds until the next read.
- R4: Size code 1 is a half-word access and size codes 2 and 3 are word accesses. Any such read at channel offsets 0 to 3 returns all ones for its width: 0x0000FFFF for a half-word and 0xFFFFFFFF for a word.
- R5: At channel offsets 0 to 3, two kinds of write have no effect: any write wider than a byte, and a byte write to offset 1 or 3.
- R6: A byte write to offset 0 stores bit 0 as start and bit 3 as direction (1 means the device writes to memory). All other command bits read as 0. The start and direction outputs show the new values on the following clock. Clearing start while the engine is active drops the start output on that clock.
- R7: A byte write to offset 2 has four effects. Status bits 5 and 6 take the written values. Bits 1 and 2 clear wherever the written byte has a 1. Bit 0 does not change. Bits 3, 4 and 7 read as 0.
- R8: Status bit 0 follows the engine's active input with one clock of delay. The block never changes bit 0 in any other way.
- R9: An error pulse sets status bit 1 and an interrupt pulse sets status bit 2. If a pulse lands in the same clock as a write-1-to-clear of that bit, the bit ends up set.
- R10: A write at offsets 4 to 7 updates the table pointer, with byte lanes counted from 0 at offset 4. The access covers the lanes from the offset's lane (address bits 1:0) onward, for the access size (1, 2 or 4 bytes). Its data comes from the low bytes of the write data. Lanes beyond lane 3 are dropped. Pointer bits 1:0 are always 0. The table output shows the new pointer on the following clock.
- R11: A read at offsets 4 to 7 returns the table pointer shifted right by 8 times address bits 1:0, masked to the access width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 4 | Byte address within the window |
| io_size | input | 2 | Access size: 0 byte, 1 half-word, 2 or 3 word |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 32 | Write data, low-byte aligned |
| io_rdata | output | 32 | Registered read data |
| eng_active | input | 2 | Per-channel transfer-in-progress level |
| eng_err | input | 2 | Per-channel error pulse |
| eng_irq | input | 2 | Per-channel interrupt pulse |
| dma_start | output | 2 | Per-channel start/stop control |
| dma_to_mem | output | 2 | Per-channel direction, 1 = device writes memory |
| dma_table | output | 64 | Table pointers, channel 0 in bits 31:0 |

## Verification
The bench fires an error pulse in the same clock as a write-1-to-clear of that flag. A design where the clear wins would lose that event. The bench also tries wide reads and writes on the command and status bytes. A design that decodes size carelessly would return real register bytes there, or would corrupt the command byte. The bench writes the table pointer at unaligned offsets with wide sizes. Wrong lane steering would land bytes in the wrong place or wrap beyond lane 3. The bench also stops a running channel while its active input is high. A design that cleared the activity bit itself, or delayed the start output, would miscompare.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORDX = 2'd3
  } io_size_e;

  // offsets within the command/status group
  localparam logic [1:0] OFS_CMD  = 2'd0;
  localparam logic [1:0] OFS_STAT = 2'd2;

  // command and status bit positions
  localparam int CMD_RUN   = 0;
  localparam int CMD_DIR   = 3;
  localparam int ST_ACT    = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_IRQ    = 2;
  localparam int ST_CAP_LO = 5;
  localparam int ST_CAP_HI = 6;

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_mask = 32'h0000_00FF;
      SZ_HALF: size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic int size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_bytes = 1;
      SZ_HALF: size_bytes = 2;
      default: size_bytes = 4;
    endcase
  endfunction
endpackage

// File: rtl/bmd_ctl_stat.sv
module bmd_ctl_stat
  import bmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_cmd,
  input  logic       wr_stat,
  input  logic [7:0] wbyte,
  input  logic       act,
  input  logic       err,
  input  logic       irq,
  output logic [7:0] cmd,
  output logic [7:0] stat
);
  logic [7:0] cmd_nx;
  logic [7:0] stat_nx;

  always_comb begin
    cmd_nx = cmd;
    if (wr_cmd) begin
      cmd_nx          = '0;
      cmd_nx[CMD_RUN] = wbyte[CMD_RUN];
      cmd_nx[CMD_DIR] = wbyte[CMD_DIR];
    end
  end

  always_comb begin
    stat_nx = stat;
    if (wr_stat) begin
      stat_nx[ST_CAP_LO] = wbyte[ST_CAP_LO];
      stat_nx[ST_CAP_HI] = wbyte[ST_CAP_HI];
      stat_nx[ST_ERR]    = stat[ST_ERR] & ~wbyte[ST_ERR];
      stat_nx[ST_IRQ]    = stat[ST_IRQ] & ~wbyte[ST_IRQ];
    end
    // engine events take priority over software clears
    if (err) stat_nx[ST_ERR] = 1'b1;
    if (irq) stat_nx[ST_IRQ] = 1'b1;
    stat_nx[ST_ACT] = act;
    stat_nx[7]      = 1'b0;
    stat_nx[4:3]    = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd  <= '0;
      stat <= '0;
    end else begin
      cmd  <= cmd_nx;
      stat <= stat_nx;
    end
  end
endmodule

// File: rtl/bmd_table_ptr.sv
module bmd_table_ptr
  import bmd_pkg::*;
#(
  parameter int PTR_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [1:0]        lane,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] wdata,
  output logic [PTR_W-1:0]  ptr
);
  localparam int LANES = PTR_W / BYTE_W;

  logic [PTR_W-1:0] ptr_nx;

  always_comb begin
    ptr_nx = ptr;
    for (int j = 0; j < LANES; j++) begin
      if (wr && (j >= int'(lane)) && (j < int'(lane) + size_bytes(size))) begin
        ptr_nx[j*BYTE_W +: BYTE_W] = wdata[(j - int'(lane))*BYTE_W +: BYTE_W];
      end
    end
    ptr_nx[1:0] = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else     ptr <= ptr_nx;
  end
endmodule

// File: rtl/bmd_rd_mux.sv
module bmd_rd_mux
  import bmd_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int PTR_W  = 32,
  parameter int DATA_W = 32,
  parameter int CSEL_W = 1
) (
  input  logic [CSEL_W-1:0]    csel,
  input  logic [2:0]           ofs,
  input  logic [1:0]           size,
  input  logic [NCH*8-1:0]     cmd_all,
  input  logic [NCH*8-1:0]     stat_all,
  input  logic [NCH*PTR_W-1:0] ptr_all,
  output logic [DATA_W-1:0]    rval
);
  logic [7:0]       cmd_s;
  logic [7:0]       stat_s;
  logic [PTR_W-1:0] ptr_s;

  always_comb begin
    cmd_s  = '0;
    stat_s = '0;
    ptr_s  = '0;
    for (int c = 0; c < NCH; c++) begin
      if (int'(csel) == c) begin
        cmd_s  = cmd_all[c*8 +: 8];
        stat_s = stat_all[c*8 +: 8];
        ptr_s  = ptr_all[c*PTR_W +: PTR_W];
      end
    end
  end

  always_comb begin
    rval = '0;
    if (ofs[2]) begin
      rval = DATA_W'((ptr_s >> (8 * ofs[1:0])) & PTR_W'(size_mask(size)));
    end else if (size != SZ_BYTE) begin
      rval = DATA_W'(size_mask(size));
    end else begin
      case (ofs[1:0])
        OFS_CMD:  rval = DATA_W'(cmd_s);
        OFS_STAT: rval = DATA_W'(stat_s);
        default:  rval = DATA_W'(8'hFF);
      endcase
    end
  end
endmodule

// File: rtl/bmd_regfile.sv
module bmd_regfile
  import bmd_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int PTR_W  = 32,
  parameter int DATA_W = 32,
  localparam int CSEL_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W = 3 + CSEL_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic [1:0]           io_size,
  input  logic                 io_rd,
  input  logic                 io_wr,
  input  logic [DATA_W-1:0]    io_wdata,
  output logic [DATA_W-1:0]    io_rdata,
  input  logic [NCH-1:0]       eng_active,
  input  logic [NCH-1:0]       eng_err,
  input  logic [NCH-1:0]       eng_irq,
  output logic [NCH-1:0]       dma_start,
  output logic [NCH-1:0]       dma_to_mem,
  output logic [NCH*PTR_W-1:0] dma_table
);
  logic [CSEL_W-1:0]    csel;
  logic [2:0]           ofs;
  logic                 byte_acc;
  logic [NCH*8-1:0]     cmd_all;
  logic [NCH*8-1:0]     stat_all;
  logic [DATA_W-1:0]    rval;

  assign csel     = io_addr[ADDR_W-1:3];
  assign ofs      = io_addr[2:0];
  assign byte_acc = (io_size == SZ_BYTE);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = io_wr && (int'(csel) == c);

    bmd_ctl_stat u_cs (
      .clk     (clk),
      .rst     (rst),
      .wr_cmd  (hit && byte_acc && ofs == {1'b0, OFS_CMD}),
      .wr_stat (hit && byte_acc && ofs == {1'b0, OFS_STAT}),
      .wbyte   (io_wdata[7:0]),
      .act     (eng_active[c]),
      .err     (eng_err[c]),
      .irq     (eng_irq[c]),
      .cmd     (cmd_all[c*8 +: 8]),
      .stat    (stat_all[c*8 +: 8])
    );

    bmd_table_ptr #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_tp (
      .clk   (clk),
      .rst   (rst),
      .wr    (hit && ofs[2]),
      .lane  (ofs[1:0]),
      .size  (io_size),
      .wdata (io_wdata),
      .ptr   (dma_table[c*PTR_W +: PTR_W])
    );

    assign dma_start[c]  = cmd_all[c*8 + CMD_RUN];
    assign dma_to_mem[c] = cmd_all[c*8 + CMD_DIR];
  end

  bmd_rd_mux #(.NCH(NCH), .PTR_W(PTR_W), .DATA_W(DATA_W), .CSEL_W(CSEL_W)) u_rd (
    .csel     (csel),
    .ofs      (ofs),
    .size     (io_size),
    .cmd_all  (cmd_all),
    .stat_all (stat_all),
    .ptr_all  (dma_table),
    .rval     (rval)
  );

  always_ff @(posedge clk) begin
    if (rst)        io_rdata <= '0;
    else if (io_rd) io_rdata <= rval;
  end
endmodule

// File: rtl/bmd_regfile_chk.sv
module bmd_regfile_chk #(
  parameter int NCH    = 2,
  parameter int PTR_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    io_addr,
  input logic [1:0]           io_size,
  input logic                 io_rd,
  input logic                 io_wr,
  input logic [DATA_W-1:0]    io_wdata,
  input logic [DATA_W-1:0]    io_rdata,
  input logic [NCH-1:0]       dma_start,
  input logic [NCH-1:0]       dma_to_mem,
  input logic [NCH*PTR_W-1:0] dma_table
);
  // R4: a word read in the command/status group gives all ones
  p_wide_read_r4: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !io_addr[2] && io_size[1]) |=> (io_rdata == {DATA_W{1'b1}}));

  // R3: a byte read at an odd group offset gives 0xFF
  p_odd_read_r3: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !io_addr[2] && io_addr[0] && io_size == 2'd0) |=> (io_rdata == DATA_W'(8'hFF)));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R6: a byte write to the command byte drives start and direction
    p_start_r6: assert property (@(posedge clk) disable iff (rst)
      (io_wr && int'(io_addr[ADDR_W-1:3]) == c && io_addr[2:0] == 3'd0 && io_size == 2'd0)
      |=> (dma_start[c] == $past(io_wdata[0]) && dma_to_mem[c] == $past(io_wdata[3])));

    // R5: wide writes to the group leave the command byte alone
    p_wide_wr_r5: assert property (@(posedge clk) disable iff (rst)
      (io_wr && int'(io_addr[ADDR_W-1:3]) == c && !io_addr[2] && io_size != 2'd0)
      |=> ($stable(dma_start[c]) && $stable(dma_to_mem[c])));

    // R10: an aligned word write loads the pointer with bits 1:0 zero
    p_ptr_word_r10: assert property (@(posedge clk) disable iff (rst)
      (io_wr && int'(io_addr[ADDR_W-1:3]) == c && io_addr[2:0] == 3'd4 && io_size[1])
      |=> (dma_table[c*PTR_W +: PTR_W] == {$past(io_wdata[PTR_W-1:2]), 2'b00}));
  end
endmodule

bind bmd_regfile bmd_regfile_chk #(
  .NCH(NCH), .PTR_W(PTR_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .io_addr    (io_addr),
  .io_size    (io_size),
  .io_rd      (io_rd),
  .io_wr      (io_wr),
  .io_wdata   (io_wdata),
  .io_rdata   (io_rdata),
  .dma_start  (dma_start),
  .dma_to_mem (dma_to_mem),
  .dma_table  (dma_table)
);

// File: tb/sim_bmd_regfile.sv
module sim_bmd_regfile;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  io_addr;
  logic [1:0]  io_size;
  logic        io_rd, io_wr;
  logic [31:0] io_wdata;
  logic [31:0] io_rdata;
  logic [1:0]  eng_active, eng_err, eng_irq;
  logic [1:0]  dma_start, dma_to_mem;
  logic [63:0] dma_table;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0]  m_cmd  [2];
  logic [7:0]  m_st   [2];
  logic [31:0] m_ptr  [2];
  logic [31:0] m_rd;
  string       rd_tag;

  always #2 clk = ~clk;

  bmd_regfile u0 (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_size(io_size),
    .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .eng_active(eng_active), .eng_err(eng_err), .eng_irq(eng_irq),
    .dma_start(dma_start), .dma_to_mem(dma_to_mem), .dma_table(dma_table)
  );

  function automatic logic [31:0] mask_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] a, input logic [1:0] sz);
    int c = int'(a[3]);
    if (a[2])          return (m_ptr[c] >> (8 * a[1:0])) & mask_of(sz);   // R11
    if (sz != 2'd0)    return mask_of(sz);                                // R4
    if (a[1:0] == 2'd0) return {24'h0, m_cmd[c]};
    if (a[1:0] == 2'd2) return {24'h0, m_st[c]};
    return 32'hFF;                                                        // R3
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // advance the reference model by one clock for the inputs now driven
  task automatic model_step();
    int nb = (io_size == 2'd0) ? 1 : (io_size == 2'd1) ? 2 : 4;
    if (io_rd) begin
      m_rd = exp_read(io_addr, io_size);
      rd_tag = io_addr[2] ? "R11" : (io_size != 0) ? "R4" : "R3";
    end
    for (int c = 0; c < 2; c++) begin
      logic sel = io_wr && (int'(io_addr[3]) == c);
      logic [7:0] s = m_st[c];
      if (sel && io_size == 0 && io_addr[2:0] == 3'd0)
        m_cmd[c] = io_wdata[7:0] & 8'h09;
      if (sel && io_size == 0 && io_addr[2:0] == 3'd2) begin
        s[6:5] = io_wdata[6:5];
        s[2:1] = s[2:1] & ~io_wdata[2:1];
      end
      s[1] = s[1] | eng_err[c];
      s[2] = s[2] | eng_irq[c];
      s[0] = eng_active[c];
      s[7] = 1'b0; s[4:3] = 2'b00;
      m_st[c] = s;
      if (sel && io_addr[2]) begin
        for (int j = 0; j < 4; j++) begin
          int k = j - int'(io_addr[1:0]);
          if (k >= 0 && k < nb) m_ptr[c][8*j +: 8] = io_wdata[8*k +: 8];
        end
        m_ptr[c][1:0] = 2'b00;
      end
    end
  endtask

  task automatic compare_all();
    chk(rd_tag, {32'h0, io_rdata}, {32'h0, m_rd});
    chk("R6", {62'h0, dma_start},  {62'h0, m_cmd[1][0], m_cmd[0][0]});
    chk("R6", {62'h0, dma_to_mem}, {62'h0, m_cmd[1][3], m_cmd[0][3]});
    chk("R10", dma_table, {m_ptr[1], m_ptr[0]});
  endtask

  // drive one cycle at the falling edge, then check at the next one
  task automatic cyc(input logic rd, input logic wr, input logic [3:0] a,
                     input logic [1:0] sz, input logic [31:0] wd,
                     input logic [1:0] act, input logic [1:0] er, input logic [1:0] iq);
    io_rd = rd; io_wr = wr; io_addr = a; io_size = sz; io_wdata = wd;
    eng_active = act; eng_err = er; eng_irq = iq;
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    io_rd = 0; io_wr = 0; io_addr = 0; io_size = 0; io_wdata = 0;
    eng_active = 0; eng_err = 0; eng_irq = 0;
    for (int c = 0; c < 2; c++) begin m_cmd[c] = 0; m_st[c] = 0; m_ptr[c] = 0; end
    m_rd = 0; rd_tag = "R3";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", {32'h0, io_rdata}, 64'h0);
    chk("R1", {60'h0, dma_start, dma_to_mem}, 64'h0);
    chk("R1", dma_table, 64'h0);
    cyc(1, 0, 4'h2, 0, 0, 0, 0, 0);
    chk("R1", {32'h0, io_rdata}, 64'h0);

    // R6: command write on channel 1, R2: channel 0 untouched
    cyc(0, 1, 4'h8, 0, 32'hFF, 0, 0, 0);
    chk("R6", {62'h0, dma_start}, 64'h2);
    cyc(1, 0, 4'h8, 0, 0, 0, 0, 0);
    chk("R6", {32'h0, io_rdata}, 64'h09);
    cyc(1, 0, 4'h0, 0, 0, 0, 0, 0);
    chk("R2", {32'h0, io_rdata}, 64'h00);

    // R5: wide write and odd-offset write ignored
    cyc(0, 1, 4'h8, 1, 32'h0, 0, 0, 0);
    cyc(0, 1, 4'h9, 0, 32'h0, 0, 0, 0);
    cyc(0, 1, 4'hB, 0, 32'h0, 0, 0, 0);
    cyc(1, 0, 4'h8, 0, 0, 0, 0, 0);
    chk("R5", {32'h0, io_rdata}, 64'h09);

    // R8: activity bit follows engine
    cyc(0, 0, 4'h0, 0, 0, 2'b10, 0, 0);
    cyc(1, 0, 4'hA, 0, 0, 2'b10, 0, 0);
    chk("R8", {32'h0, io_rdata}, 64'h01);

    // R9: error set wins over simultaneous clear; capability bits written
    cyc(0, 1, 4'h2, 0, 32'h66, 0, 2'b01, 0);
    cyc(1, 0, 4'h2, 0, 0, 0, 0, 0);
    chk("R9", {32'h0, io_rdata}, 64'h62);
    // R7: write-1-to-clear of bit 1, capability bits kept by written value
    cyc(0, 1, 4'h2, 0, 32'hFE, 0, 0, 2'b01);
    cyc(1, 0, 4'h2, 0, 0, 0, 0, 0);
    chk("R7", {32'h0, io_rdata}, 64'h64);

    // R4: wide reads of the group
    cyc(1, 0, 4'h0, 2, 0, 0, 0, 0);
    chk("R4", {32'h0, io_rdata}, 64'hFFFF_FFFF);
    cyc(1, 0, 4'h1, 1, 0, 0, 0, 0);
    chk("R4", {32'h0, io_rdata}, 64'h0000_FFFF);

    // R10 / R11: table pointer lanes
    cyc(0, 1, 4'h4, 2, 32'h1234_5677, 0, 0, 0);
    chk("R10", {32'h0, dma_table[31:0]}, 64'h1234_5674);
    cyc(0, 1, 4'h7, 0, 32'hAB, 0, 0, 0);
    cyc(0, 1, 4'h6, 2, 32'hDDCC_BBEE, 0, 0, 0);
    chk("R10", {32'h0, dma_table[31:0]}, 64'hBBEE_5674);
    cyc(1, 0, 4'h6, 1, 0, 0, 0, 0);
    chk("R11", {32'h0, io_rdata}, 64'hBBEE);

    // R6: stop while active drops start; R8 activity bit unchanged
    cyc(0, 1, 4'h8, 0, 32'h08, 2'b10, 0, 0);
    chk("R6", {62'h0, dma_start}, 64'h0);
    cyc(1, 0, 4'hA, 0, 0, 2'b10, 0, 0);
    chk("R8", {63'h0, io_rdata[0]}, 64'h1);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] sz = ($urandom % 4 == 0) ? 2'($urandom) : 2'd0;
      cyc(1'($urandom), 1'($urandom), 4'($urandom), sz, $urandom,
          2'($urandom), ($urandom % 5 == 0) ? 2'($urandom) : 2'b00,
          ($urandom % 5 == 0) ? 2'($urandom) : 2'b00);
    end
    io_rd = 0; io_wr = 0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule